// File: doc/BRIEF.md
# Serial Receiver with Flag-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches a serial line, finds the falling edge that opens each frame, and confirms the start bit halfway through the bit time. It then collects eight data bits, least significant first, an optional parity bit and one stop bit. An external enable, `bitTick`, sets the timing: it pulses sixteen times per bit period. Each recovered byte is written to a receive queue as a 12-bit entry. The entry holds the byte and four error flags.

The line settings control how the parity bit is checked. With parity off, the receiver expects no parity bit. With parity on, it checks for even or odd parity. With stick parity also on, it compares the parity bit against a fixed level. When the queue is turned off, storage shrinks to a single holding entry. The reader sees the head entry on `rxWord`, sees `rxEmpty`, and pops the head with a one-cycle `rdStrobe`.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset, `rxEmpty` is 1 and no entry is stored until a full frame has been received.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The byte appears in `rxWord[7:0]` with all flags clear when parity matches and the stop bit is high.
- R3: A low pulse on the line that ends before the eighth tick after the falling edge is seen is not taken as a start bit, and no entry is stored.
- R4: When `parityOn`=1 and `stickOn`=0, `rxWord[9]` is set if the received parity bit does not give an even number of ones over data and parity (`evenSel`=1), or an odd number (`evenSel`=0).
- R5: When `parityOn`=1 and `stickOn`=1, the parity bit must equal the inverse of `evenSel`: 1 when `evenSel`=0 and 0 when `evenSel`=1. Otherwise `rxWord[9]` is set.
- R6: When `parityOn`=0, no parity bit is expected, the bit after the eighth data bit is taken as the stop bit, and `rxWord[9]` is never set.
- R7: A low stop-bit sample on a frame that is not a break sets the framing flag `rxWord[8]`.
- R8: A line held low through the data, parity and stop times gives exactly one entry with data 0, the break flag `rxWord[10]` set, and `rxWord[9:8]` clear. No further frame starts until the line returns high.
- R9: With `queueOn`=1, up to DEPTH (default 16) entries are held and read back in arrival order.
- R10: When a frame completes while storage is full, the new byte is discarded, the overrun flag `rxWord[11]` is set on the newest stored entry, and the entry count does not change.
- R11: With `queueOn`=0, storage holds a single entry. A second frame that arrives before the first is read sets `rxWord[11]` on the held entry and is discarded.
- R12: A high `rdStrobe` while `rxEmpty`=0 removes the head entry in that cycle. A high `rdStrobe` while `rxEmpty`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Oversample enable, 16 pulses per bit period |
| rxLine | input | 1 | Serial input; idles high |
| queueOn | input | 1 | 1 = multi-entry queue, 0 = single holding entry |
| parityOn | input | 1 | 1 = a parity bit follows the data |
| evenSel | input | 1 | 1 = even parity, 0 = odd parity |
| stickOn | input | 1 | 1 = parity bit is checked against a fixed level |
| rdStrobe | input | 1 | Pops the head entry when the queue is not empty |
| rxWord | output | 12 | Head entry: {overrun, break, parity, framing, data[7:0]} |
| rxEmpty | output | 1 | 1 when no entry is stored |

## Verification
Random frames cover random bytes under every mix of parity on/off, even/odd and stick. Some frames carry a deliberately flipped parity bit or a low stop bit. These frames show whether the parity rule follows the configuration and whether framing errors are kept apart from parity errors. A zero byte with a low stop bit must be classed as a break rather than a framing error. Directed cases cover a short low glitch (start rejection), a long low line (a single break entry), filling the queue past its depth (overrun on the newest entry), single-entry mode, and popping an empty queue. These cases tell storage limits and ordering apart from the frame decoding.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic sampleData;
    logic samplePar;
    logic frameEnd;
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      rxSync,
  input  logic      parityOn,
  output rxStrobe_t strobe
);

  localparam int CNT_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF   = OVS / 2;

  rxState_t state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [BIT_W-1:0] bitIdx, bitIdxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
    end
  end

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    strobe      = '0;
    case (state)
      ST_IDLE: begin
        if (bitTick && !rxSync) begin
          stateNext   = ST_START;
          tickCntNext = '0;
        end
      end
      ST_START: begin
        if (bitTick) begin
          if (tickCnt == CNT_W'(HALF - 1)) begin
            tickCntNext = '0;
            bitIdxNext  = '0;
            if (!rxSync) begin
              stateNext         = ST_DATA;
              strobe.startFrame = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bitTick) begin
          if (tickCnt == CNT_W'(OVS - 1)) begin
            tickCntNext       = '0;
            strobe.sampleData = 1'b1;
            if (bitIdx == BIT_W'(DATA_W - 1)) begin
              stateNext = parityOn ? ST_PAR : ST_STOP;
            end else begin
              bitIdxNext = bitIdx + 1'b1;
            end
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bitTick) begin
          if (tickCnt == CNT_W'(OVS - 1)) begin
            tickCntNext      = '0;
            strobe.samplePar = 1'b1;
            stateNext        = ST_STOP;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (bitTick) begin
          if (tickCnt == CNT_W'(OVS - 1)) begin
            tickCntNext     = '0;
            strobe.frameEnd = 1'b1;
            stateNext       = rxSync ? ST_IDLE : ST_HOLD;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (rxSync) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2: at most one sampling action per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.sampleData, strobe.samplePar, strobe.frameEnd}));

  // R8: after a low stop sample no new frame opens while the line stays low
  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && !rxSync) |=> !strobe.startFrame);

endmodule

// File: rtl/serial_rx_data.sv
module serial_rx_data
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              rxSync,
  input  logic              queueOn,
  input  logic              parityOn,
  input  logic              evenSel,
  input  logic              stickOn,
  input  logic              rdStrobe,
  output logic [DATA_W+3:0] rxWord,
  output logic              rxEmpty
);

  localparam int ENTRY_W = DATA_W + 4;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;

  logic [DATA_W-1:0]  shiftReg;
  logic               parBit;
  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr, lastPtr;
  logic [CNT_W-1:0]   count;
  logic               isBreak, frameErr, parErr, parExpect, full, doPop, doPush;
  logic [ENTRY_W-1:0] newEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.startFrame) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.sampleData) begin
      shiftReg <= {rxSync, shiftReg[DATA_W-1:1]};
    end else if (strobe.samplePar) begin
      parBit <= rxSync;
    end
  end

  always_comb begin
    isBreak   = (shiftReg == '0) && !parBit && !rxSync;
    frameErr  = !rxSync && !isBreak;
    parExpect = stickOn ? ~evenSel : (evenSel ? ^shiftReg : ~^shiftReg);
    parErr    = parityOn && !isBreak && (parBit != parExpect);
    newEntry  = {1'b0, isBreak, parErr, frameErr, shiftReg};
  end

  assign full    = queueOn ? (count == CNT_W'(DEPTH)) : (count != '0);
  assign rxEmpty = (count == '0);
  assign doPop   = rdStrobe && !rxEmpty;
  assign doPush  = strobe.frameEnd && !full;
  assign lastPtr = wrPtr - 1'b1;
  assign rxWord  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) begin
      store[wrPtr] <= newEntry;
    end else if (strobe.frameEnd) begin
      store[lastPtr][ENTRY_W-1] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the configured depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10: a frame arriving into full storage leaves the occupancy unchanged
  a_r10_full_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && full && !doPop) |=> (count == $past(count)));

  // R12: a pop without a simultaneous push removes exactly one entry
  a_r12_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !rxEmpty && !strobe.frameEnd) |=> (count == $past(count) - 1'b1));

  // R12: a strobe on empty storage does not change anything
  a_r12_empty_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rxEmpty && !strobe.frameEnd) |=> rxEmpty);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              rxLine,
  input  logic              queueOn,
  input  logic              parityOn,
  input  logic              evenSel,
  input  logic              stickOn,
  input  logic              rdStrobe,
  output logic [DATA_W+3:0] rxWord,
  output logic              rxEmpty
);

  logic      rxMeta, rxSync;
  rxStrobe_t strobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  serial_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .rxSync   (rxSync),
    .parityOn (parityOn),
    .strobe   (strobe)
  );

  serial_rx_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxSync   (rxSync),
    .queueOn  (queueOn),
    .parityOn (parityOn),
    .evenSel  (evenSel),
    .stickOn  (stickOn),
    .rdStrobe (rdStrobe),
    .rxWord   (rxWord),
    .rxEmpty  (rxEmpty)
  );

endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every second clock
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        rxLine = 1'b1;
  logic        queueOn = 1'b1;
  logic        parityOn = 1'b0;
  logic        evenSel = 1'b0;
  logic        stickOn = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [11:0] rxWord;
  logic        rxEmpty;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  serial_rx_queue dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
    .queueOn(queueOn), .parityOn(parityOn), .evenSel(evenSel), .stickOn(stickOn),
    .rdStrobe(rdStrobe), .rxWord(rxWord), .rxEmpty(rxEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    bitTick = ~bitTick;
  end

  function automatic logic goodParity(input logic [7:0] d, input logic pEven, input logic pStick);
    if (pStick) return ~pEven;
    return pEven ? ^d : ~^d;
  endfunction

  function automatic logic [11:0] expectEntry(input logic [7:0] d, input logic pOn,
      input logic pEven, input logic pStick, input logic pSent, input logic stopBit);
    logic brk, fe, pe;
    brk = (d == 8'h00) && (!pOn || !pSent) && !stopBit;
    fe  = !stopBit && !brk;
    pe  = pOn && !brk && (pSent != goodParity(d, pEven, pStick));
    return {1'b0, brk, pe, fe, d};
  endfunction

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic pSent, input logic stopBit);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (parityOn) holdBit(pSent);
    holdBit(stopBit);
    holdBit(1'b1);
  endtask

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic readCheck(input logic [11:0] exp, input string req);
    @(negedge clk);
    check(!rxEmpty, {req, " (entry present)"}, {11'd0, rxEmpty}, 12'd0);
    check(rxWord === exp, req, rxWord, exp);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic checkEmpty(input string req);
    @(negedge clk);
    check(rxEmpty === 1'b1, req, {11'd0, rxEmpty}, 12'd1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic pSent, stopBit;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkEmpty("R1 empty after reset");
    repeat (BIT_CLKS * 3) @(negedge clk);
    checkEmpty("R1 idle line stores nothing");

    // R2: plain frame, no parity
    sendFrame(8'hA5, 1'b0, 1'b1);
    readCheck(12'h0A5, "R2 basic byte");

    // R3: short glitch rejected
    rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    checkEmpty("R3 glitch ignored");

    // R12: strobe on empty has no effect, next frame is the only entry
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    checkEmpty("R12 pop on empty");
    sendFrame(8'h3C, 1'b0, 1'b1);
    readCheck(12'h03C, "R12 entry after empty pop");
    checkEmpty("R12 single pop");

    // R4 R5 R6 R7: random configurations and corruptions
    for (int n = 0; n < 40; n++) begin
      d        = 8'($urandom);
      parityOn = 1'($urandom);
      evenSel  = 1'($urandom);
      stickOn  = 1'($urandom);
      pSent    = goodParity(d, evenSel, stickOn) ^ ($urandom_range(0, 3) == 0);
      stopBit  = ($urandom_range(0, 4) != 0);
      if (n % 9 == 0) d = 8'h00;
      sendFrame(d, pSent, stopBit);
      readCheck(expectEntry(d, parityOn, evenSel, stickOn, pSent, stopBit),
                parityOn ? (stickOn ? "R5 stick parity" : "R4 even/odd parity")
                         : (stopBit ? "R6 no parity" : "R7 framing"));
    end

    // R4: directed odd parity error
    parityOn = 1'b1; evenSel = 1'b0; stickOn = 1'b0;
    sendFrame(8'h01, 1'b1, 1'b1);
    readCheck(12'h201, "R4 odd parity wrong bit");
    // R5: stick with even select expects 0
    evenSel = 1'b1; stickOn = 1'b1;
    sendFrame(8'h7F, 1'b0, 1'b1);
    readCheck(12'h07F, "R5 stick low ok");
    // R7: framing error
    stickOn = 1'b0;
    sendFrame(8'h81, 1'b0, 1'b0);
    readCheck(12'h181, "R7 framing with parity");

    // R8: long break gives one entry
    holdBit(1'b0);
    for (int i = 0; i < 14; i++) holdBit(1'b0);
    holdBit(1'b1);
    holdBit(1'b1);
    readCheck(12'h400, "R8 break entry");
    checkEmpty("R8 single break entry");

    // R9 R10: fill beyond depth
    parityOn = 1'b0;
    for (int i = 0; i < DEPTH + 1; i++) sendFrame(8'(8'h10 + i), 1'b0, 1'b1);
    for (int i = 0; i < DEPTH - 1; i++) readCheck(12'(8'h10 + i), "R9 queue order");
    readCheck(12'h800 | 12'(8'h10 + DEPTH - 1), "R10 overrun on newest");
    checkEmpty("R10 extra byte discarded");

    // R11: single holding entry
    queueOn = 1'b0;
    sendFrame(8'h55, 1'b0, 1'b1);
    sendFrame(8'hAA, 1'b0, 1'b1);
    readCheck(12'h855, "R11 holding overrun");
    checkEmpty("R11 second byte discarded");
    sendFrame(8'hC3, 1'b0, 1'b1);
    readCheck(12'h0C3, "R11 holding reuse");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule